// File: doc/BRIEF.md
# XOR-Encoded Register File with One Write and One Read per Cycle

This block is a register file that accepts one write and one read in every clock cycle. It is built only from single-port synchronous SRAM copies and holds no flip-flop storage array. The storage is split into two banks. The value of a word is the bitwise XOR of the two banks' entries at that address. A write goes to one bank, which stores the new data XORed with the other bank's current entry, so the XOR of the two banks becomes the new data. Writes alternate between the banks on successive cycles.

Each bank has three single-port copies, so the file uses six in total. In the cycle a bank is the write target, one copy takes the write, one copy serves the lookup that encodes the next write, and one copy serves the read port. In the following cycle the two lagging copies take the same write, and the up-to-date copy serves the read.

Writes carry one enable per byte lane, so partial writes are supported. A parameter chooses how a read and a write to the same address in the same cycle interact. In transparent mode the read returns the new data on the written lanes. In non-transparent mode the read returns the old word.

Top module: `xor_regfile_1w1r`

## Requirements
- R1: The word read at `rd_addr` appears on `rd_data` right after the next rising clock edge, and a read is performed in every cycle.
- R2: After reset, every word that has never been written reads as zero.
- R3: A full write stores all of `wr_data`, and a later read of that address returns it.
- R4: There are DW/LW lanes. Lane l is bits [l*LW+LW-1 : l*LW] and is written only when `wr_lanes[l]` is 1. Lanes that are not enabled keep their previous contents.
- R5: A write with `wr_lanes` all zero changes no stored word.
- R6: A read in the cycle right after a write to the same address returns the newly written lanes, in both modes.
- R7: With TRANSPARENT=1, a read of the address written in the same cycle returns `wr_data` on the enabled lanes and the stored data on the other lanes.
- R8: With TRANSPARENT=0, a read of the address written in the same cycle returns the contents that address held before that write.
- R9: Writes to other addresses do not change the value read from an address.
- R10: Writes to the same address on back-to-back cycles with different lane masks merge correctly, and the latest write wins on each lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the pipeline registers |
| wr_addr | input | AW | Write address |
| wr_lanes | input | DW/LW | Per-lane write enables |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address, sampled every cycle |
| rd_data | output | DW | Read result, one cycle after the address |

## Verification
A wrong encoding in either bank is silent until that address is read, and then it shows as a corrupted word. The damage is usually confined to the lanes of the bad write, because decoding XORs both banks. A missed forward between back-to-back writes to one address shows up one or two cycles later as a stale lane. It appears either on the bypassed read or on the next read of that word, so dense same-address traffic with random lane masks exposes it within a few cycles. A copy that falls out of step inside a bank shows only when the read port switches to that copy, which happens on alternate cycles, so the error appears within two reads of the affected address.

// File: rtl/xrf_sram_1rw.sv
`timescale 1ns/1ps
module xrf_sram_1rw #(
  parameter int DW = 32,
  parameter int LW = 8,
  parameter int DEPTH = 32,
  localparam int NL = DW / LW,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          cs,
  input  logic [NL-1:0] wm,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH] = '{default: '0};
  logic [DW-1:0] q = '0;

  always_ff @(posedge clk) begin
    if (cs) begin
      if (|wm) begin
        for (int l = 0; l < NL; l++)
          if (wm[l]) mem[addr][l*LW +: LW] <= wdata[l*LW +: LW];
      end else begin
        q <= mem[addr];
      end
    end
  end

  assign rdata = q;
endmodule

// File: rtl/xor_regfile_1w1r.sv
`timescale 1ns/1ps
module xor_regfile_1w1r #(
  parameter int DW = 32,
  parameter int LW = 8,
  parameter int DEPTH = 32,
  parameter int TRANSPARENT = 1,
  localparam int NL = DW / LW,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] wr_addr,
  input  logic [NL-1:0] wr_lanes,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic          ph;
  logic          s1_vld, s2_vld, r_ph;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NL-1:0] s1_mask, s2_mask, r_new, r_old;
  logic [DW-1:0] s1_data, s2_enc, r_wd, r_od;
  logic [DW-1:0] lk, enc, b0q, b1q, xq;

  logic          c_cs [2][3];
  logic [NL-1:0] c_wm [2][3];
  logic [AW-1:0] c_ad [2][3];
  logic [DW-1:0] c_wd [2][3];
  logic [DW-1:0] c_rd [2][3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      s1_mask <= '0;
      s1_data <= '0;
      s2_vld  <= 1'b0;
      s2_addr <= '0;
      s2_mask <= '0;
      s2_enc  <= '0;
      r_ph    <= 1'b0;
      r_new   <= '0;
      r_old   <= '0;
      r_wd    <= '0;
      r_od    <= '0;
    end else begin
      ph      <= ~ph;
      s1_vld  <= |wr_lanes;
      s1_addr <= wr_addr;
      s1_mask <= wr_lanes;
      s1_data <= wr_data;
      s2_vld  <= s1_vld;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
      s2_enc  <= enc;
      r_ph    <= ph;
      r_wd    <= wr_data;
      r_od    <= s1_data;
      for (int l = 0; l < NL; l++) begin
        r_new[l] <= (TRANSPARENT != 0) && wr_lanes[l] && (wr_addr == rd_addr);
        r_old[l] <= s1_vld && s1_mask[l] && (s1_addr == rd_addr);
      end
    end
  end

  assign lk  = c_rd[ph][1];
  assign b0q = r_ph ? c_rd[0][2] : c_rd[0][0];
  assign b1q = r_ph ? c_rd[1][0] : c_rd[1][2];
  assign xq  = b0q ^ b1q;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic fwd;
    assign fwd = s2_vld && s2_mask[l] && (s2_addr == s1_addr);
    assign enc[l*LW +: LW] = s1_data[l*LW +: LW] ^ (fwd ? s2_enc[l*LW +: LW] : lk[l*LW +: LW]);
    assign rd_data[l*LW +: LW] = r_new[l] ? r_wd[l*LW +: LW] :
                                 r_old[l] ? r_od[l*LW +: LW] : xq[l*LW +: LW];
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic busy;
    assign busy = (b == 0) ? ph : ~ph;

    assign c_cs[b][0] = busy ? s1_vld : 1'b1;
    assign c_wm[b][0] = busy ? s1_mask : '0;
    assign c_ad[b][0] = busy ? s1_addr : rd_addr;
    assign c_wd[b][0] = enc;

    assign c_cs[b][1] = busy ? (|wr_lanes) : s2_vld;
    assign c_wm[b][1] = busy ? '0 : s2_mask;
    assign c_ad[b][1] = busy ? wr_addr : s2_addr;
    assign c_wd[b][1] = s2_enc;

    assign c_cs[b][2] = busy ? 1'b1 : s2_vld;
    assign c_wm[b][2] = busy ? '0 : s2_mask;
    assign c_ad[b][2] = busy ? rd_addr : s2_addr;
    assign c_wd[b][2] = s2_enc;

    for (genvar c = 0; c < 3; c++) begin : g_copy
      xrf_sram_1rw #(.DW(DW), .LW(LW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .cs    (c_cs[b][c]),
        .wm    (c_wm[b][c]),
        .addr  (c_ad[b][c]),
        .wdata (c_wd[b][c]),
        .rdata (c_rd[b][c])
      );
    end
  end
endmodule

// File: rtl/xrf_checker.sv
`timescale 1ns/1ps
module xrf_checker #(
  parameter int DW = 32,
  parameter int LW = 8,
  parameter int DEPTH = 32,
  parameter int TRANSPARENT = 1,
  localparam int NL = DW / LW,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] wr_addr,
  input logic [NL-1:0] wr_lanes,
  input logic [DW-1:0] wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  for (genvar l = 0; l < NL; l++) begin : g_l
    AST_SAME_CYCLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (TRANSPARENT != 0 && age >= 2'd1 && $past(wr_lanes[l]) && $past(wr_addr) == $past(rd_addr))
      |-> rd_data[l*LW +: LW] == $past(wr_data[l*LW +: LW])); // R7

    AST_NEXT_CYCLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(wr_lanes[l], 2) && $past(wr_addr, 2) == $past(rd_addr)
       && !($past(wr_lanes[l]) && $past(wr_addr) == $past(rd_addr)))
      |-> rd_data[l*LW +: LW] == $past(wr_data[l*LW +: LW], 2)); // R6
  end

  AST_OTHER_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(rd_addr) == $past(rd_addr, 2)
     && ($past(wr_lanes, 2) == '0 || $past(wr_addr, 2) != $past(rd_addr))
     && ($past(wr_lanes) == '0 || $past(wr_addr) != $past(rd_addr)))
    |-> $stable(rd_data)); // R9

  AST_NONTRANSP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (TRANSPARENT == 0 && age == 2'd3 && $past(rd_addr) == $past(rd_addr, 2)
     && ($past(wr_lanes, 2) == '0 || $past(wr_addr, 2) != $past(rd_addr)))
    |-> $stable(rd_data)); // R8
endmodule

bind xor_regfile_1w1r xrf_checker #(.DW(DW), .LW(LW), .DEPTH(DEPTH), .TRANSPARENT(TRANSPARENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_xor_regfile_1w1r.sv
`timescale 1ns/1ps
module tb_xor_regfile_1w1r;
  localparam int DW = 32, LW = 8, DEPTH = 32, NL = DW / LW, AW = $clog2(DEPTH);

  typedef struct {
    logic [DW-1:0] exp_tr;
    logic [DW-1:0] exp_nt;
    string         tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [NL-1:0] wr_lanes = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_tr, rd_nt;
  logic [DW-1:0] ref_mem [DEPTH];
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xor_regfile_1w1r #(.DW(DW), .LW(LW), .DEPTH(DEPTH), .TRANSPARENT(1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_tr));

  xor_regfile_1w1r #(.DW(DW), .LW(LW), .DEPTH(DEPTH), .TRANSPARENT(0)) dut_nt (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_nt));

  task automatic drive(input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                       input logic [NL-1:0] wm, input logic [DW-1:0] wd, input string tag);
    item_t it;
    logic [DW-1:0] cur, nxt;
    @(negedge clk);
    rd_addr = ra; wr_addr = wa; wr_lanes = wm; wr_data = wd;
    cur = ref_mem[ra];
    nxt = ref_mem[wa];
    for (int l = 0; l < NL; l++)
      if (wm[l]) nxt[l*LW +: LW] = wd[l*LW +: LW];
    it.exp_nt = cur;
    it.exp_tr = (wa == ra) ? nxt : cur;
    it.tag = tag;
    q.push_back(it);
    ref_mem[wa] = nxt;
  endtask

  always @(posedge clk) begin
    item_t it;
    #1;
    if (rst_n && q.size() > 0) begin
      it = q.pop_front();
      checks += 2;
      if (rd_tr !== it.exp_tr) begin
        errors++;
        $display("FAIL %s transparent: rd_data=%h expected=%h", it.tag, rd_tr, it.exp_tr);
      end
      if (rd_nt !== it.exp_nt) begin
        errors++;
        $display("FAIL %s non-transparent: rd_data=%h expected=%h", it.tag, rd_nt, it.exp_nt);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2, R1: never-written words read zero with one-cycle latency
    for (int i = 0; i < DEPTH; i++) drive(AW'(i), '0, '0, '1, "R2");
    // R5: data on a write with no lanes enabled is discarded
    drive(AW'(6), AW'(6), '0, 32'hDEAD_BEEF, "R5");
    drive(AW'(6), AW'(7), '0, 32'h1234_5678, "R5");
    // R3: fill every word, then read back
    for (int i = 0; i < DEPTH; i++) drive(AW'((i + 9) % DEPTH), AW'(i), '1, $urandom, "R3");
    for (int i = 0; i < DEPTH; i++) drive(AW'(i), '0, '0, '0, "R3");
    // R4: partial lanes
    drive(AW'(5), AW'(5), 4'b0101, 32'hAABB_CCDD, "R4");
    drive(AW'(5), AW'(3), 4'b1000, 32'h1100_0000, "R4");
    drive(AW'(3), '0, '0, '0, "R4");
    // R6: read right after write
    drive(AW'(1), AW'(10), '1, 32'h0BAD_F00D, "R6");
    drive(AW'(10), AW'(11), '0, '0, "R6");
    drive(AW'(12), AW'(12), 4'b0011, 32'h5555_6666, "R6");
    drive(AW'(12), AW'(20), 4'b1111, 32'h7777_8888, "R6");
    // R7, R8: same-cycle collisions, full and partial
    drive(AW'(14), AW'(14), '1, 32'hCAFE_0001, "R7");
    drive(AW'(14), AW'(14), 4'b0110, 32'h0F0F_0F0F, "R8");
    drive(AW'(14), AW'(14), 4'b1001, 32'hF0F0_F0F0, "R7");
    drive(AW'(14), '0, '0, '0, "R8");
    // R9: writes elsewhere while reading one word
    for (int i = 0; i < 16; i++) drive(AW'(2), AW'(16 + i), '1, $urandom, "R9");
    // R10: back-to-back writes to one address with changing masks
    for (int i = 0; i < 24; i++) drive(AW'(4), AW'(4), NL'(1 << (i % NL)) | NL'(i[0]), $urandom, "R10");
    drive(AW'(4), '0, '0, '0, "R10");
    // R10, R7, R8: random traffic on a few addresses to force collisions
    for (int i = 0; i < 3000; i++)
      drive(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)), NL'($urandom), $urandom, "R10");
    // R9: random traffic over the whole range
    for (int i = 0; i < 2000; i++)
      drive(AW'($urandom), AW'($urandom), NL'($urandom), $urandom, "R9");
    drive('0, '0, '0, '0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule